// File: doc/BRIEF.md
# Overwriting Return Address Stack

This block keeps the return addresses of a small processor core in a fixed number of hardware levels. A subroutine call or an interrupt entry pushes the address to resume at. A return, from a subroutine or from an interrupt, pops it. The levels form a shift register and there is no pointer. A push moves every entry one level deeper. A pop moves every entry one level shallower.

The stack never reports a fault. When too many calls are made, the oldest address falls off the deep end. When too many returns are made, the deepest level keeps its content, so the same address comes back again. This matches firmware that nests only as deep as the stack allows.

The returned address is read straight from the top level, with no register in between. The sequencer can therefore use it in the same cycle it raises the pop strobe.

Top module: `ras_stack`

## Requirements
- R1: While `rst_ni` is low, every level is cleared to zero. Until the first push after reset, `pop_addr_o` reads 0, and pops return 0.
- R2: A push without a pop loads `push_addr_i` into the top level at the clock edge. From the following cycle, `pop_addr_o` shows that address.
- R3: A push without a pop moves each level's content one level deeper. The content of the deepest level is lost.
- R4: `pop_addr_o` always equals the top level, combinationally. The returned address is therefore valid in the same cycle as the pop strobe.
- R5: A pop without a push moves each level's content one level shallower at the clock edge.
- R6: With the default depth of 3, pushing A1, A2, A3 and A4 with no pop in between, then popping four times, returns A4, A3, A2 and then A2 again.
- R7: On a pop, the deepest level keeps its old content. Further pops past the bottom keep returning that value.
- R8: When push and pop are strobed in the same cycle, the top level takes `push_addr_i` and all deeper levels stay unchanged. In that cycle `pop_addr_o` still shows the old top.
- R9: With neither strobe raised, no level changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push strobe (call or interrupt entry) |
| push_addr_i | input | ADDR_W (9) | Return address to push |
| pop_i | input | 1 | Pop strobe (return or return from interrupt) |
| pop_addr_o | output | ADDR_W (9) | Current top level, the address a pop returns |

## Verification
The bench builds the block with its defaults: three levels of nine bits. At this size a single four-push burst already overruns the stack, so R6 and R7 are checked against the exact A4, A3, A2, A2 order within a few cycles. The nine-bit width lets the addresses used include the all-ones value 0x1FF and zero, which is also the reset value. Simultaneous push and pop is checked with deeper levels that are already filled, so any unwanted shift shows up in the later pops.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } ras_op_e;

endpackage

// File: rtl/ras_op_decode.sv
module ras_op_decode
  import ras_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  output ras_op_e op_o
);

  always_comb begin
    unique case ({push_i, pop_i})
      2'b10:   op_o = OP_PUSH;
      2'b01:   op_o = OP_POP;
      2'b11:   op_o = OP_SWAP;
      default: op_o = OP_HOLD;
    endcase
  end

endmodule

// File: rtl/ras_level.sv
module ras_level
  import ras_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter bit          IS_TOP = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ras_op_e           op_i,
  input  logic [ADDR_W-1:0] from_shallow_i, // top level: the pushed address
  input  logic [ADDR_W-1:0] from_deep_i,    // bottom level: its own content
  output logic [ADDR_W-1:0] q_o
);

  logic [ADDR_W-1:0] d;

  always_comb begin
    unique case (op_i)
      OP_PUSH: d = from_shallow_i;
      OP_POP:  d = from_deep_i;
      OP_SWAP: d = IS_TOP ? from_shallow_i : q_o;
      default: d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
  end

endmodule

// File: rtl/ras_stack.sv
module ras_stack
  import ras_pkg::*;
#(
  parameter int unsigned DEPTH  = 3,
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] pop_addr_o
);

  localparam int unsigned LAST = DEPTH - 1;

  ras_op_e                      op;
  logic [DEPTH-1:0][ADDR_W-1:0] lvl_q;

  ras_op_decode u_dec (
    .push_i (push_i),
    .pop_i  (pop_i),
    .op_o   (op)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
    logic [ADDR_W-1:0] shallow, deep;
    if (g == 0) begin : g_top
      assign shallow = push_addr_i;
    end else begin : g_mid_s
      assign shallow = lvl_q[g-1];
    end
    if (g == LAST) begin : g_bot
      assign deep = lvl_q[g]; // bottom holds on pop
    end else begin : g_mid_d
      assign deep = lvl_q[g+1];
    end

    ras_level #(
      .ADDR_W (ADDR_W),
      .IS_TOP (g == 0)
    ) u_level (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .op_i           (op),
      .from_shallow_i (shallow),
      .from_deep_i    (deep),
      .q_o            (lvl_q[g])
    );
  end

  assign pop_addr_o = lvl_q[0];

endmodule

// File: rtl/ras_stack_chk.sv
module ras_stack_chk #(
  parameter int unsigned DEPTH  = 3,
  parameter int unsigned ADDR_W = 9
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         push_i,
  input logic [ADDR_W-1:0]            push_addr_i,
  input logic                         pop_i,
  input logic [ADDR_W-1:0]            pop_addr_o,
  input logic [DEPTH-1:0][ADDR_W-1:0] lvl_q
);

  a_r2_push_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> pop_addr_o == $past(push_addr_i));

  a_r3_push_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> lvl_q[1] == $past(lvl_q[0]));

  a_r3_push_deepest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> lvl_q[DEPTH-1] == $past(lvl_q[DEPTH-2]));

  a_r5_pop_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> pop_addr_o == $past(lvl_q[1]));

  a_r7_bottom_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> lvl_q[DEPTH-1] == $past(lvl_q[DEPTH-1]));

  a_r8_swap_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> pop_addr_o == $past(push_addr_i));

  a_r8_swap_deep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> lvl_q[DEPTH-1:1] == $past(lvl_q[DEPTH-1:1]));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> $stable(lvl_q));

endmodule

bind ras_stack ras_stack_chk #(
  .DEPTH  (DEPTH),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .push_addr_i (push_addr_i),
  .pop_i       (pop_i),
  .pop_addr_o  (pop_addr_o),
  .lvl_q       (lvl_q)
);

// File: tb/ras_stack_tb_top.sv
module ras_stack_tb_top;

  localparam int unsigned AW = 9;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          push_i = 1'b0;
  logic          pop_i = 1'b0;
  logic [AW-1:0] push_addr_i = '0;
  logic [AW-1:0] pop_addr_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  ras_stack #(.DEPTH(3), .ADDR_W(AW)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .push_addr_i (push_addr_i),
    .pop_i       (pop_i),
    .pop_addr_o  (pop_addr_o)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    push_i = 1'b0; pop_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic push(input logic [AW-1:0] a);
    @(negedge clk_i);
    push_i = 1'b1; pop_i = 1'b0; push_addr_i = a;
    @(negedge clk_i);
    push_i = 1'b0;
  endtask

  // Checks the address during the pop cycle itself (R4), then lets it shift.
  task automatic pop(input string req, input logic [AW-1:0] exp);
    @(negedge clk_i);
    pop_i = 1'b1; push_i = 1'b0;
    #1 chk(req, pop_addr_o, exp);
    @(negedge clk_i);
    pop_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1 chk("R1 top after reset", pop_addr_o, 9'h000);
    push(9'h155); push(9'h0AA); push(9'h1FF);
    do_reset();
    #1 chk("R1 top cleared", pop_addr_o, 9'h000);
    pop("R1 pop after reset", 9'h000);
    pop("R1 pop level1 cleared", 9'h000);
    pop("R1 pop level2 cleared", 9'h000);
  endtask

  task automatic t_push_pop();
    do_reset();
    push(9'h011);
    #1 chk("R2 top after push", pop_addr_o, 9'h011);
    push(9'h022);
    #1 chk("R2 newest on top", pop_addr_o, 9'h022);
    pop("R4 same-cycle pop", 9'h022);
    #1 chk("R5 shift up", pop_addr_o, 9'h011);
    pop("R3 older moved deeper", 9'h011);
  endtask

  task automatic t_overflow();
    do_reset();
    push(9'h101); push(9'h0A2); push(9'h1F3); push(9'h054);
    pop("R6 first pop A4", 9'h054);
    pop("R6 second pop A3", 9'h1F3);
    pop("R6 third pop A2", 9'h0A2);
    pop("R7 bottom repeats A2", 9'h0A2);
    pop("R7 bottom repeats again", 9'h0A2);
  endtask

  task automatic t_swap();
    do_reset();
    push(9'h0B1); push(9'h0B2); push(9'h0B0);
    @(negedge clk_i);
    push_i = 1'b1; pop_i = 1'b1; push_addr_i = 9'h1B3;
    #1 chk("R8 old top visible in swap cycle", pop_addr_o, 9'h0B0);
    @(negedge clk_i);
    push_i = 1'b0; pop_i = 1'b0;
    #1 chk("R8 new top", pop_addr_o, 9'h1B3);
    pop("R8 pop new top", 9'h1B3);
    pop("R8 level1 unchanged", 9'h0B2);
    pop("R8 level2 unchanged", 9'h0B1);
  endtask

  task automatic t_idle();
    do_reset();
    push(9'h1FF); push(9'h000); push(9'h0C7);
    repeat (6) @(negedge clk_i);
    #1 chk("R9 top held idle", pop_addr_o, 9'h0C7);
    pop("R9 pop after idle", 9'h0C7);
    pop("R9 zero address held", 9'h000);
    pop("R9 all-ones held", 9'h1FF);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_push_pop();
    t_overflow();
    t_swap();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule